// File: doc/BRIEF.md
# Ring Buffer Packet Resync Extractor

This block pulls the unread portion out of a circular command ring held in a synchronous RAM of 32-bit words. The caller supplies the ring size in bytes, a read pointer and a write pointer, all in words except the size. The read pointer is not treated as a packet boundary. The block first moves the pointer back by a fixed lookback distance, wrapping below zero. It then walks forward one word at a time until a word passes the header test, giving up once the lookback distance is used. The words from that resynchronised start up to the write pointer are then streamed out in ring order, wrapping at the end of the ring.

The ring RAM has a one-cycle read latency: data requested with `mem_rd` and `mem_addr` on one clock edge is valid on `mem_rdata` during the following cycle. The header test is a small combinational unit. In the newer-generation mode it accepts two packet type codes in the top nibble of a word. In the older mode it accepts every word. Extracted words leave on a valid/ready stream that carries a last flag, and a one-cycle `done` pulse closes every job, including a job with nothing to send. The ring size in words must exceed the lookback distance.

Controller states: IDLE (waits for `start`), SCAN_RD (issues a read at the candidate position), SCAN_CHK (tests the returned word), COUNT (computes the unread span), STR_RD (issues a stream read), STR_CAP (captures the returned word), STR_OUT (offers the word downstream) and DONE (pulses `done`). The transitions are:
- IDLE to SCAN_RD on an accepted start.
- SCAN_RD to SCAN_CHK.
- SCAN_CHK to COUNT on a header hit or on an exhausted lookback, and otherwise back to SCAN_RD.
- COUNT to DONE for an empty span, and otherwise to STR_RD.
- STR_RD to STR_CAP, and STR_CAP to STR_OUT.
- STR_OUT to STR_RD or, after the final word, to DONE, both on a handshake.
- DONE to IDLE.

Top module: `ring_resync_extract`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `out_valid`, `out_last`, `done` and `mem_rd` are all 0.
- R2: The ring holds `ring_bytes >> 2` words, with the two low bits of `ring_bytes` ignored, and every RAM read addresses a word below that size.
- R3: The scan begins LOOKBACK (default 12) words before `rd_ptr`, taken modulo the ring size, so a read pointer near zero rewinds into the top of the ring.
- R4: The scan examines words in ascending ring order, and the first word that passes the header test becomes the stream start. This holds even when that word is the first one or the twelfth one examined.
- R5: If none of the LOOKBACK examined words passes, the stream starts at `rd_ptr` itself.
- R6: With `gen_new`=1, a word passes only if its bits [31:28] equal 4 or 7, so any other value (for example 1 or 5) fails. With `gen_new`=0, every word passes, so the start is always `rd_ptr` minus LOOKBACK, modulo the ring size.
- R7: The number of words streamed equals (`wr_ptr` − start) modulo the ring size. Word k is the RAM content at (start + k) modulo the ring size.
- R8: `out_last` is high together with the final streamed word only.
- R9: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with `out_data` and `out_last` unchanged.
- R10: When the unread span is zero, no word is offered, and the job ends with the `done` pulse.
- R11: `done` is high for exactly one cycle after the last handshake (or after the span calculation for an empty span). `out_valid` is never high at the same time, and `busy` is low in the cycle after.
- R12: `start` is ignored while `busy` is high, so the running job finishes with its original ring size, pointers and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a job, accepted only when idle |
| gen_new | input | 1 | 1 selects the two-type header test, 0 accepts every word |
| ring_bytes | input | ADDR_W+3 | Ring size in bytes |
| rd_ptr | input | ADDR_W | Read pointer in words |
| wr_ptr | input | ADDR_W | Write pointer in words |
| busy | output | 1 | A job is in progress |
| mem_rd | output | 1 | RAM read strobe |
| mem_addr | output | ADDR_W | RAM word address |
| mem_rdata | input | WORD_W | RAM read data, one cycle after the strobe |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | WORD_W | Stream word |
| out_last | output | 1 | Final word of the job |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bound assertions check on every cycle that reads stay inside the ring latched at launch and that a stalled word holds steady. They also check that `last` only comes with `valid`, that `done` is a lone pulse with no data beside it and is followed by idle, and that an idle start is always taken. Which word becomes the start, and how the rewind wraps, can only be shown by the bench's planted headers in rings of several sizes. The same is true of the span count across the wrap, the empty-span path, the older all-pass mode, the lookback limit and the refusal of a second start.

// File: rtl/rsx_pkg.sv
package rsx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN_RD,
        ST_SCAN_CHK,
        ST_COUNT,
        ST_STR_RD,
        ST_STR_CAP,
        ST_STR_OUT,
        ST_DONE
    } rsx_state_t;

endpackage

// File: rtl/rsx_hdr_check.sv
module rsx_hdr_check #(
    parameter int                TYPE_W = 4,
    parameter logic [TYPE_W-1:0] TYPE_A = 4'h4,
    parameter logic [TYPE_W-1:0] TYPE_B = 4'h7
) (
    input  logic [TYPE_W-1:0] typ,
    input  logic              gen_new,
    output logic              ok
);

    // Older generation: no structure to test, every word may start a packet.
    always_comb begin
        if (gen_new) ok = (typ == TYPE_A) || (typ == TYPE_B);
        else         ok = 1'b1;
    end

endmodule

// File: rtl/rsx_ptr_unit.sv
module rsx_ptr_unit #(
    parameter int ADDR_W   = 8,
    parameter int LOOKBACK = 12
) (
    input  logic [ADDR_W:0]   ring_words,
    input  logic [ADDR_W-1:0] rptr,
    input  logic [ADDR_W-1:0] wptr,
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] rewound,
    output logic [ADDR_W-1:0] cur_next,
    output logic [ADDR_W:0]   span
);

    localparam int SZ_W = ADDR_W + 1;
    localparam logic [SZ_W-1:0] LB = SZ_W'(LOOKBACK);

    logic [SZ_W-1:0] r_ext, c_ext, w_ext, c_inc, rew_full;

    assign r_ext = {1'b0, rptr};
    assign c_ext = {1'b0, cur};
    assign w_ext = {1'b0, wptr};
    assign c_inc = c_ext + 1'b1;

    always_comb begin
        // rewind, wrapping below zero
        if (r_ext >= LB) rew_full = r_ext - LB;
        else             rew_full = r_ext + ring_words - LB;
        rewound = rew_full[ADDR_W-1:0];

        // single step forward, wrapping at the ring end
        if (c_inc == ring_words) cur_next = '0;
        else                     cur_next = c_inc[ADDR_W-1:0];

        // unread distance from cur to the write pointer
        if (w_ext >= c_ext) span = w_ext - c_ext;
        else                span = w_ext + ring_words - c_ext;
    end

endmodule

// File: rtl/rsx_ctrl.sv
module rsx_ctrl
    import rsx_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int LOOKBACK = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gen_new,
    input  logic [ADDR_W:0]   size_in,
    input  logic [ADDR_W-1:0] wptr_in,
    input  logic [ADDR_W-1:0] rewound,
    input  logic [ADDR_W-1:0] cur_next,
    input  logic [ADDR_W:0]   span,
    input  logic              hdr_ok,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              out_ready,
    output logic [ADDR_W:0]   ring_words,
    output logic [ADDR_W-1:0] wptr_q,
    output logic [ADDR_W-1:0] cur_q,
    output logic              mode_q,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic              done
);

    localparam int STEP_W = $clog2(LOOKBACK + 1);
    localparam logic [STEP_W-1:0] STEP_END = STEP_W'(LOOKBACK - 1);

    rsx_state_t        state_q, state_d;
    logic [ADDR_W:0]   size_q;
    logic [ADDR_W:0]   rem_q;
    logic [STEP_W-1:0] steps_q;
    logic [WORD_W-1:0] data_q;
    logic              launch;

    assign launch     = (state_q == ST_IDLE) && start;
    assign ring_words = (state_q == ST_IDLE) ? size_in : size_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_SCAN_RD;
            ST_SCAN_RD:  state_d = ST_SCAN_CHK;
            ST_SCAN_CHK: begin
                if (hdr_ok || steps_q == STEP_END) state_d = ST_COUNT;
                else                               state_d = ST_SCAN_RD;
            end
            ST_COUNT:    state_d = (span == '0) ? ST_DONE : ST_STR_RD;
            ST_STR_RD:   state_d = ST_STR_CAP;
            ST_STR_CAP:  state_d = ST_STR_OUT;
            ST_STR_OUT: begin
                if (out_ready) state_d = (rem_q == 1) ? ST_DONE : ST_STR_RD;
            end
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // job registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q  <= '0;
            wptr_q  <= '0;
            mode_q  <= 1'b0;
            cur_q   <= '0;
            steps_q <= '0;
            rem_q   <= '0;
            data_q  <= '0;
        end else begin
            if (launch) begin
                size_q  <= size_in;
                wptr_q  <= wptr_in;
                mode_q  <= gen_new;
                cur_q   <= rewound;
                steps_q <= '0;
            end
            if (state_q == ST_SCAN_CHK && !hdr_ok) begin
                cur_q   <= cur_next;
                steps_q <= steps_q + 1'b1;
            end
            if (state_q == ST_COUNT)   rem_q  <= span;
            if (state_q == ST_STR_CAP) data_q <= mem_rdata;
            if (state_q == ST_STR_OUT && out_ready) begin
                cur_q <= cur_next;
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_rd    = (state_q == ST_SCAN_RD) || (state_q == ST_STR_RD);
        mem_addr  = cur_q;
        out_valid = (state_q == ST_STR_OUT);
        out_last  = (state_q == ST_STR_OUT) && (rem_q == 1);
        out_data  = data_q;
        done      = (state_q == ST_DONE);
    end

endmodule

// File: rtl/ring_resync_extract.sv
module ring_resync_extract #(
    parameter int                TYPE_W   = 4,
    parameter int                WORD_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter int                LOOKBACK = 12,
    parameter logic [TYPE_W-1:0] TYPE_A   = 4'h4,
    parameter logic [TYPE_W-1:0] TYPE_B   = 4'h7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gen_new,
    input  logic [ADDR_W+2:0] ring_bytes,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic [ADDR_W-1:0] wr_ptr,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic              done
);

    logic [ADDR_W:0]   size_in, ring_words, span;
    logic [ADDR_W-1:0] rewound, cur_next, cur_q, wptr_q;
    logic              mode_q, hdr_ok;
    logic              unused_byte_lsbs;

    assign size_in          = ring_bytes[ADDR_W+2:2];
    assign unused_byte_lsbs = ^ring_bytes[1:0];

    rsx_hdr_check #(
        .TYPE_W (TYPE_W),
        .TYPE_A (TYPE_A),
        .TYPE_B (TYPE_B)
    ) u_hdr (
        .typ     (mem_rdata[WORD_W-1 -: TYPE_W]),
        .gen_new (mode_q),
        .ok      (hdr_ok)
    );

    rsx_ptr_unit #(
        .ADDR_W   (ADDR_W),
        .LOOKBACK (LOOKBACK)
    ) u_ptr (
        .ring_words (ring_words),
        .rptr       (rd_ptr),
        .wptr       (wptr_q),
        .cur        (cur_q),
        .rewound    (rewound),
        .cur_next   (cur_next),
        .span       (span)
    );

    rsx_ctrl #(
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .LOOKBACK (LOOKBACK)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .gen_new    (gen_new),
        .size_in    (size_in),
        .wptr_in    (wr_ptr),
        .rewound    (rewound),
        .cur_next   (cur_next),
        .span       (span),
        .hdr_ok     (hdr_ok),
        .mem_rdata  (mem_rdata),
        .out_ready  (out_ready),
        .ring_words (ring_words),
        .wptr_q     (wptr_q),
        .cur_q      (cur_q),
        .mode_q     (mode_q),
        .busy       (busy),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .done       (done)
    );

endmodule

// File: rtl/rsx_checker.sv
module rsx_checker #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [ADDR_W+2:0] ring_bytes,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last,
    input logic              done
);

    logic [ADDR_W:0] chk_size;
    logic            unused_chk_lsbs;

    assign unused_chk_lsbs = ^ring_bytes[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               chk_size <= '0;
        else if (start && !busy)  chk_size <= ring_bytes[ADDR_W+2:2];
    end

    p_addr_in_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (busy && ({1'b0, mem_addr} < chk_size)));

    p_last_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_launch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind ring_resync_extract rsx_checker #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_rsx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .ring_bytes (ring_bytes),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .done       (done)
);

// File: tb/tb_ring_resync_extract.sv
`timescale 1ns/1ps
module tb_ring_resync_extract;

    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [8:0] NONE = 9'h1FF;

    typedef struct packed {
        logic [10:0] bytes;
        logic [7:0]  rptr;
        logic [7:0]  wptr;
        logic        newgen;
        logic [8:0]  h1;
        logic [3:0]  t1;
        logic [8:0]  h2;
        logic [3:0]  t2;
        logic [7:0]  est;
        logic [8:0]  ecnt;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{11'd256,  8'd20, 8'd30,  1'b1, 9'd10,  4'h4, NONE,   4'h0, 8'd10,  9'd20},
        '{11'd256,  8'd5,  8'd9,   1'b1, 9'd60,  4'h7, NONE,   4'h0, 8'd60,  9'd13},
        '{11'd256,  8'd20, 8'd25,  1'b1, NONE,   4'h0, NONE,   4'h0, 8'd20,  9'd5},
        '{11'd256,  8'd20, 8'd25,  1'b0, NONE,   4'h0, NONE,   4'h0, 8'd8,   9'd17},
        '{11'd256,  8'd30, 8'd30,  1'b1, NONE,   4'h0, NONE,   4'h0, 8'd30,  9'd0},
        '{11'd400,  8'd3,  8'd97,  1'b1, 9'd95,  4'h4, NONE,   4'h0, 8'd95,  9'd2},
        '{11'd400,  8'd50, 8'd10,  1'b1, 9'd38,  4'h7, NONE,   4'h0, 8'd38,  9'd72},
        '{11'd259,  8'd62, 8'd2,   1'b1, 9'd55,  4'h5, 9'd63,  4'h7, 8'd62,  9'd4},
        '{11'd256,  8'd40, 8'd41,  1'b1, 9'd39,  4'h4, NONE,   4'h0, 8'd39,  9'd2},
        '{11'd256,  8'd4,  8'd6,   1'b0, NONE,   4'h0, NONE,   4'h0, 8'd56,  9'd14},
        '{11'd1024, 8'd0,  8'd255, 1'b1, 9'd250, 4'h7, NONE,   4'h0, 8'd250, 9'd5}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              gen_new = 1'b0;
    logic [10:0]       ring_bytes = '0;
    logic [7:0]        rd_ptr = '0;
    logic [7:0]        wr_ptr = '0;
    logic              out_ready = 1'b1;
    logic              busy, mem_rd, out_valid, out_last, done;
    logic [7:0]        mem_addr;
    logic [WORD_W-1:0] mem_rdata, out_data;
    logic [WORD_W-1:0] ram [DEPTH];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) mem_rdata <= ram[mem_addr];
    end

    ring_resync_extract dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gen_new(gen_new),
        .ring_bytes(ring_bytes), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic string start_tag(input int vi);
        case (vi)
            0, 6, 8: return "R4 start";
            1, 5:    return "R3 start";
            2, 7:    return "R5 start";
            3, 9:    return "R6 start";
            10:      return "R2 start";
            11:      return "R12 start";
            default: return "R4 start";
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input int vi, input bit inject);
        int          size_w;
        int          n;
        bit          seen_done, addr_bad, hold_prev, rdy;
        logic [31:0] pd, expw;
        logic        pl;
        size_w = int'(v.bytes) >> 2;
        for (int i = 0; i < DEPTH; i++) ram[i] = {4'h1, 12'h000, 16'(i)};
        if (v.h1 != NONE) ram[v.h1[7:0]] = {v.t1, 12'h000, 8'h00, v.h1[7:0]};
        if (v.h2 != NONE) ram[v.h2[7:0]] = {v.t2, 12'h000, 8'h00, v.h2[7:0]};
        @(negedge clk);
        ring_bytes = v.bytes; rd_ptr = v.rptr; wr_ptr = v.wptr; gen_new = v.newgen; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            // R12: second launch attempt with different settings while busy
            @(negedge clk);
            ring_bytes = 11'd40; rd_ptr = 8'd0; wr_ptr = 8'd1; gen_new = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0; seen_done = 0; addr_bad = 0; hold_prev = 0; pd = '0; pl = 1'b0;
        for (int c = 0; c < 4000 && !seen_done; c++) begin
            @(negedge clk);
            if (hold_prev)
                chk(out_valid && out_data == pd && out_last == pl, "R9 stalled word held", out_data, pd);
            if (mem_rd && int'(mem_addr) >= size_w) addr_bad = 1;
            if (done) seen_done = 1;
            rdy = (vi % 2 == 1) ? (c % 3 != 0) : 1'b1;
            out_ready = rdy;
            if (out_valid && out_ready) begin
                expw = ram[(int'(v.est) + n) % size_w];
                if (n == 0) chk(out_data == expw, start_tag(vi), out_data, expw);
                else        chk(out_data == expw, "R7 stream word", out_data, expw);
                chk(out_last == (n == int'(v.ecnt) - 1), "R8 last flag", 32'(out_last), 32'(n == int'(v.ecnt) - 1));
                n++;
            end
            hold_prev = out_valid && !out_ready;
            pd = out_data; pl = out_last;
        end
        out_ready = 1'b1;
        chk(seen_done, "R11 done pulse seen", 32'(seen_done), 32'd1);
        if (v.ecnt == 0) chk(n == 0, "R10 empty span emits nothing", n, 0);
        else             chk(n == int'(v.ecnt), "R7 word count", n, 32'(v.ecnt));
        chk(!addr_bad, "R2 address inside ring", 32'(addr_bad), 32'd0);
        @(negedge clk);
        chk(!busy && !done, "R11 idle after done", {busy, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held and after release
        chk(!busy && !out_valid && !out_last && !done && !mem_rd, "R1 reset state",
            {busy, out_valid, out_last, done, mem_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !out_valid && !out_last && !done && !mem_rd, "R1 after release",
            {busy, out_valid, out_last, done, mem_rd}, 32'd0);

        for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi, 1'b0);

        // directed: start ignored while busy (R12)
        run_vec(VECS[0], 11, 1'b1);

        // directed: reset in the middle of a stream returns to R1 state
        run_vec(VECS[6], 0, 1'b0);
        @(negedge clk);
        ring_bytes = 11'd256; rd_ptr = 8'd20; wr_ptr = 8'd30; gen_new = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !out_valid && !done && !mem_rd, "R1 mid-job reset", {busy, out_valid, done, mem_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        report();
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        report();
    end

endmodule